// File: doc/BRIEF.md
# Dual-Link Frame Checker and Selector

The block takes one frame that reaches it twice, once over a primary link and once over a secondary link. Each copy is a complete 256-bit frame with a one-cycle valid strobe. The low 32 bits of each copy hold a CRC-32 computed over the upper 224 bits. The block checks each copy on its own and compares the two CRC fields. For every pair it then forwards exactly one good copy, or it reports that neither copy can be used.

When only one copy fails, processing continues on the healthy copy and a one-cycle trigger pulse is raised for software. A copy that does not turn up within a bounded wait after its partner counts as failed. A 10-bit status word records the outcome of the most recent pair. Each link has a saturating failure counter that clears when it is read, so a fault that keeps coming back can be traced to one link. Only the upper payload bits of the chosen copy are passed on; the rest of the frame is dropped.

Top module: `dual_link_select`

## Requirements
- R1: Each completed pair produces exactly one outcome, on the clock edge after the pair completes: either `out_vld` or `hard_err` is high for one cycle. A pair completes when both copies have arrived or when the wait expires. No outcome appears without a completed pair.
- R2: A copy is good when the CRC of its bits 255..32 equals its bits 31..0. The CRC uses polynomial 0x04C11DB7, initial value 0xFFFFFFFF, is fed most significant bit first, and has no reflection and no final XOR. When both copies are good and their CRC fields are equal, the primary copy is forwarded with `out_src`=0 and no trigger.
- R3: When both copies are good but their CRC fields differ, `crc_mismatch` pulses together with `out_vld`, and the primary copy is forwarded.
- R4: When exactly one copy fails, the other copy is forwarded (`out_src`=1 means secondary) and `sw_trig` pulses for that one cycle.
- R5: When both copies fail, `hard_err` pulses and `out_vld` stays low.
- R6: The second copy is accepted if its strobe comes no more than WAIT_CYC cycles after the first copy's strobe. If it has not come by then, it is treated as failed. The result then appears on the edge WAIT_CYC+1 cycles after the first strobe.
- R7: `status` holds its value from one decision to the next. Bit 0 is set when the primary copy arrived with a bad CRC and bit 1 when the secondary copy did. Bit 2 marks a missing primary copy and bit 3 a missing secondary copy. Bit 4 is a CRC mismatch, bit 5 a single failure (trigger), bit 6 a hard error and bit 7 a forward from the secondary link. Bits 8 and 9 show live whether the primary and secondary counters are saturated.
- R8: Each link has a failure counter (a missing or bad copy adds one) that saturates at all ones. Holding `rd_req` for one cycle with `rd_link` (0 = primary, 1 = secondary) returns that counter on `rd_data` on the next edge and clears it.
- R9: `out_payload` carries the top PAYLOAD_W bits (255 downward) of the forwarded copy.
- R10: After reset all outputs and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_frame | input | FRAME_W | Primary link frame |
| pri_vld | input | 1 | Primary frame strobe |
| sec_frame | input | FRAME_W | Secondary link frame |
| sec_vld | input | 1 | Secondary frame strobe |
| rd_req | input | 1 | Counter read and clear request |
| rd_link | input | 1 | Counter to read: 0 primary, 1 secondary |
| out_vld | output | 1 | Forwarded payload valid pulse |
| out_payload | output | PAYLOAD_W | Payload of the chosen copy |
| out_src | output | 1 | 1 when the secondary copy was forwarded |
| sw_trig | output | 1 | Single-copy failure pulse |
| hard_err | output | 1 | Both copies failed pulse |
| crc_mismatch | output | 1 | Both copies good but CRC fields differ |
| status | output | 10 | Outcome flags of the latest pair and saturation flags |
| rd_data | output | CNT_W | Counter value returned by a read |

## Verification
A pair whose second strobe lands on edge k gives its result after edge k+1. A pair whose second copy never arrives gives its result after edge k+WAIT_CYC+1, where k is the first strobe's edge. Counter reads answer one edge after the request. The driver pushes its predicted outcome before it drives a pair, and then waits WAIT_CYC+4 cycles, which is longer than either latency. The monitor samples on the falling edge and pops one prediction for every outcome pulse, so an early, late, missing or extra result leaves the queue out of step and is reported. Counter reads are made only while no pair is in flight, and each is checked on the falling edge after the request edge.

// File: rtl/dls_pkg.sv
// Package: shared constants for the dual-link frame selector.
// Assumes a frame carries its CRC-32 in the least significant 32 bits.
package dls_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // Bit positions of the registered part of the status word
    localparam int ST_PRI_BAD  = 0;
    localparam int ST_SEC_BAD  = 1;
    localparam int ST_PRI_MISS = 2;
    localparam int ST_SEC_MISS = 3;
    localparam int ST_MISMATCH = 4;
    localparam int ST_TRIG     = 5;
    localparam int ST_HARD     = 6;
    localparam int ST_SEC_USED = 7;
    localparam int ST_REG_W    = 8;
endpackage

// File: rtl/crc_checker.sv
// Module: crc_checker
// Recomputes the CRC-32 of one stored frame over bits FRAME_W-1..CRC_W, MSB
// first, and compares it with the trailing CRC field. Purely combinational.
// Assumes the frame is stable for the whole cycle in which the result is used.
module crc_checker
    import dls_pkg::*;
#(
    parameter int FRAME_W = 256
) (
    input  logic [FRAME_W-1:0] frame_i,
    output logic               crc_ok_o,
    output logic [CRC_W-1:0]   crc_field_o
);
    logic [CRC_W-1:0] calc;
    logic             fb;

    // Serial CRC unrolled over the data region
    always_comb begin
        calc = CRC_INIT;
        fb   = 1'b0;
        for (int i = FRAME_W - 1; i >= CRC_W; i--) begin
            fb   = calc[CRC_W-1] ^ frame_i[i];
            calc = {calc[CRC_W-2:0], 1'b0};
            if (fb) calc = calc ^ CRC_POLY;
        end
    end

    assign crc_field_o = frame_i[CRC_W-1:0];
    assign crc_ok_o    = (calc == crc_field_o);
endmodule

// File: rtl/pair_tracker.sv
// Module: pair_tracker
// Tracks which link copies of the current pair have arrived and counts the
// wait since the first one. Raises decide_o when both are present or the wait
// has run WAIT_CYC cycles. Presence is cleared on decide; a strobe arriving on
// that same edge opens the next pair.
// Assumes each link sends at most one copy per pair.
module pair_tracker #(
    parameter int WAIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] arrive_i,
    output logic [1:0] have_o,
    output logic       decide_o,
    output logic [1:0] missing_o
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic [1:0]    have_q;
    logic [1:0]    have_nxt;
    logic [CW-1:0] wait_q;
    logic          single;
    logic          timeout;

    assign single    = (have_q == 2'b01) || (have_q == 2'b10);
    assign timeout   = single && (wait_q == CW'(WAIT_CYC));
    assign decide_o  = (have_q == 2'b11) || timeout;
    assign missing_o = timeout ? ~have_q : 2'b00;
    assign have_o    = have_q;
    assign have_nxt  = (decide_o ? 2'b00 : have_q) | arrive_i;

    // Presence flags and wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= '0;
            wait_q <= '0;
        end else begin
            have_q <= have_nxt;
            if ((have_nxt == 2'b01 || have_nxt == 2'b10) && single && !decide_o)
                wait_q <= wait_q + 1'b1;
            else
                wait_q <= '0;
        end
    end
endmodule

// File: rtl/err_counter.sv
// Module: err_counter
// Saturating per-link failure counter. A clear (read) returns it to zero,
// or to one if a failure is counted on the same edge.
module err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o
);
    logic [CNT_W-1:0] cnt_q;

    assign sat_o = &cnt_q;
    assign cnt_o = cnt_q;

    // Count failures, hold at all ones, clear on read
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= {{(CNT_W-1){1'b0}}, inc_i};
        else if (inc_i && !sat_o)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dual_link_select.sv
// Module: dual_link_select (top)
// Receives redundant frame copies from a primary and a secondary link, checks
// each CRC-32, compares the CRC fields, and forwards one good copy's payload.
// Pulses sw_trig on a single-copy failure and hard_err when both fail.
// Assumes frames arrive complete with a one-cycle strobe per copy.
module dual_link_select
    import dls_pkg::*;
#(
    parameter int FRAME_W   = 256,
    parameter int PAYLOAD_W = 128,
    parameter int WAIT_CYC  = 16,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FRAME_W-1:0]   pri_frame,
    input  logic                 pri_vld,
    input  logic [FRAME_W-1:0]   sec_frame,
    input  logic                 sec_vld,
    input  logic                 rd_req,
    input  logic                 rd_link,
    output logic                 out_vld,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic                 out_src,
    output logic                 sw_trig,
    output logic                 hard_err,
    output logic                 crc_mismatch,
    output logic [9:0]           status,
    output logic [CNT_W-1:0]     rd_data
);
    localparam int NLINK = 2;

    logic [FRAME_W-1:0] in_frame [NLINK];
    logic [FRAME_W-1:0] slot_q   [NLINK];
    logic [CRC_W-1:0]   crc_field[NLINK];
    logic [CNT_W-1:0]   cnt_all  [NLINK];
    logic [NLINK-1:0]   in_vld, have, missing, crc_ok, ok, bad, sat;
    logic               pair_decide;
    logic               sel_sec;
    logic [CNT_W-1:0]   cnt_pri, cnt_sec;

    logic [ST_REG_W-1:0] status_q;

    assign in_frame[0] = pri_frame;
    assign in_frame[1] = sec_frame;
    assign in_vld      = {sec_vld, pri_vld};

    pair_tracker #(.WAIT_CYC(WAIT_CYC)) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (in_vld),
        .have_o    (have),
        .decide_o  (pair_decide),
        .missing_o (missing)
    );

    for (genvar L = 0; L < NLINK; L++) begin : g_link
        // Capture the copy on its strobe (datapath, no reset needed)
        always_ff @(posedge clk) begin
            if (in_vld[L]) slot_q[L] <= in_frame[L];
        end

        crc_checker #(.FRAME_W(FRAME_W)) crc_i (
            .frame_i     (slot_q[L]),
            .crc_ok_o    (crc_ok[L]),
            .crc_field_o (crc_field[L])
        );

        assign ok[L]  = have[L] & crc_ok[L];
        assign bad[L] = have[L] & ~crc_ok[L];

        err_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (pair_decide & ~ok[L]),
            .clr_i (rd_req && (rd_link == (L == 1))),
            .cnt_o (cnt_all[L]),
            .sat_o (sat[L])
        );
    end

    assign cnt_pri = cnt_all[0];
    assign cnt_sec = cnt_all[1];
    assign sel_sec = ~ok[0] & ok[1];

    // Register the per-pair decision and its pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld      <= 1'b0;
            out_src      <= 1'b0;
            sw_trig      <= 1'b0;
            hard_err     <= 1'b0;
            crc_mismatch <= 1'b0;
            out_payload  <= '0;
            status_q     <= '0;
        end else begin
            out_vld      <= pair_decide & (ok[0] | ok[1]);
            sw_trig      <= pair_decide & (ok[0] ^ ok[1]);
            hard_err     <= pair_decide & ~ok[0] & ~ok[1];
            crc_mismatch <= pair_decide & ok[0] & ok[1] & (crc_field[0] != crc_field[1]);
            if (pair_decide) begin
                out_src     <= sel_sec;
                out_payload <= slot_q[sel_sec][FRAME_W-1 -: PAYLOAD_W];
                status_q[ST_PRI_BAD]  <= bad[0];
                status_q[ST_SEC_BAD]  <= bad[1];
                status_q[ST_PRI_MISS] <= missing[0];
                status_q[ST_SEC_MISS] <= missing[1];
                status_q[ST_MISMATCH] <= ok[0] & ok[1] & (crc_field[0] != crc_field[1]);
                status_q[ST_TRIG]     <= ok[0] ^ ok[1];
                status_q[ST_HARD]     <= ~ok[0] & ~ok[1];
                status_q[ST_SEC_USED] <= sel_sec;
            end
        end
    end

    assign status = {sat[1], sat[0], status_q};

    // Counter read port
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_req)
            rd_data <= rd_link ? cnt_sec : cnt_pri;
    end
endmodule

// File: rtl/dual_link_select_chk.sv
// Module: dual_link_select_chk
// Property checker bound to dual_link_select.
module dual_link_select_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_vld,
    input logic             out_src,
    input logic             sw_trig,
    input logic             hard_err,
    input logic             crc_mismatch,
    input logic             pair_decide,
    input logic [CNT_W-1:0] cnt_pri,
    input logic [CNT_W-1:0] cnt_sec,
    input logic             rd_req,
    input logic             rd_link
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        pair_decide |=> (out_vld ^ hard_err)); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld || hard_err) |-> $past(pair_decide)); // R1
    AST_MISMATCH_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        crc_mismatch |-> (out_vld && !out_src && !sw_trig)); // R3
    AST_TRIG_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |-> (out_vld && !hard_err)); // R4
    AST_HARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        hard_err |-> (!out_vld && !sw_trig)); // R5
    AST_PRI_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pri == CMAX && !(rd_req && !rd_link)) |=> (cnt_pri == CMAX)); // R8
    AST_SEC_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sec == CMAX && !(rd_req && rd_link)) |=> (cnt_sec == CMAX)); // R8
endmodule

bind dual_link_select dual_link_select_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_vld      (out_vld),
    .out_src      (out_src),
    .sw_trig      (sw_trig),
    .hard_err     (hard_err),
    .crc_mismatch (crc_mismatch),
    .pair_decide  (pair_decide),
    .cnt_pri      (cnt_pri),
    .cnt_sec      (cnt_sec),
    .rd_req       (rd_req),
    .rd_link      (rd_link)
);

// File: tb/dual_link_select_tb_top.sv
// Scoreboard bench: the driver predicts each pair's outcome into a queue,
// and the monitor pops and compares on every outcome pulse.
module dual_link_select_tb_top;
    localparam int FW = 256;
    localparam int PW = 128;
    localparam int WT = 4;
    localparam int CW = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] pri_frame = '0, sec_frame = '0;
    logic          pri_vld = 1'b0, sec_vld = 1'b0, rd_req = 1'b0, rd_link = 1'b0;
    logic          out_vld, out_src, sw_trig, hard_err, crc_mismatch;
    logic [PW-1:0] out_payload;
    logic [9:0]    status;
    logic [CW-1:0] rd_data;

    always #10 clk = ~clk;  // 50 MHz

    dual_link_select #(.FRAME_W(FW), .PAYLOAD_W(PW), .WAIT_CYC(WT), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pri_frame(pri_frame), .pri_vld(pri_vld),
        .sec_frame(sec_frame), .sec_vld(sec_vld),
        .rd_req(rd_req), .rd_link(rd_link),
        .out_vld(out_vld), .out_payload(out_payload), .out_src(out_src),
        .sw_trig(sw_trig), .hard_err(hard_err), .crc_mismatch(crc_mismatch),
        .status(status), .rd_data(rd_data)
    );

    typedef struct packed {
        logic          hard;
        logic          src;
        logic          trig;
        logic          mism;
        logic [9:0]    st;
        logic [PW-1:0] pay;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0, n_fail = 0;
    int   mdl_p = 0, mdl_s = 0;
    bit   done = 0;

    function automatic logic [FW-1:0] mk_frame(int seed, bit corrupt);
        logic [FW-1:0] f;
        logic [31:0]   c;
        f = '0;
        for (int w = 0; w < 7; w++)
            f[32 + w*32 +: 32] = (32'h9E37_79B9 * (seed + w + 1)) ^ seed;
        c = 32'hFFFF_FFFF;
        for (int b = FW - 1; b >= 32; b--) begin
            if (c[31] ^ f[b]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
            else              c = {c[30:0], 1'b0};
        end
        f[31:0] = c;
        if (corrupt) f[77] = ~f[77];
        return f;
    endfunction

    task automatic check(bit cond, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: predict, push, drive one pair; sdly = secondary delay in cycles
    task automatic send_pair(int ps, bit pbad, bit psend, int ss, bit sbad, bit ssend, int sdly);
        exp_t e;
        bit okp, oks;
        okp = psend && !pbad;
        oks = ssend && !sbad;
        if (!okp) mdl_p = (mdl_p < CMAX) ? mdl_p + 1 : CMAX;
        if (!oks) mdl_s = (mdl_s < CMAX) ? mdl_s + 1 : CMAX;
        e.hard = !okp && !oks;
        e.src  = oks && !okp;
        e.trig = okp ^ oks;
        e.mism = okp && oks && (ps != ss);
        e.pay  = e.src ? mk_frame(ss, 0)[FW-1 -: PW] : mk_frame(ps, 0)[FW-1 -: PW];
        e.st   = {mdl_s == CMAX, mdl_p == CMAX, e.src, e.hard, e.trig, e.mism,
                  !ssend, !psend, ssend && sbad, psend && pbad};
        exp_q.push_back(e);
        @(negedge clk);
        pri_frame = mk_frame(ps, pbad);
        sec_frame = mk_frame(ss, sbad);
        pri_vld   = psend;
        sec_vld   = ssend && (sdly == 0);
        for (int i = 1; i <= sdly; i++) begin
            @(negedge clk);
            pri_vld = 1'b0;
            sec_vld = ssend && (i == sdly);
        end
        @(negedge clk);
        pri_vld = 1'b0;
        sec_vld = 1'b0;
        repeat (WT + 4) @(negedge clk);
        check(exp_q.size() == 0, "R1", "outcome count", 128'(exp_q.size()), 0);
        exp_q.delete();
    endtask

    task automatic read_cnt(bit link, int exp_v, string req);
        @(negedge clk);
        rd_req = 1'b1; rd_link = link;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_data == CW'(exp_v), req, link ? "sec counter" : "pri counter", 128'(rd_data), 128'(exp_v));
    endtask

    // Monitor: pop a prediction on every outcome pulse
    always @(negedge clk) begin
        if (rst_n && (out_vld || hard_err)) begin
            if (exp_q.size() == 0) begin
                check(0, "R1", "unexpected outcome", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(hard_err == e.hard && out_vld == !e.hard, "R5", "vld/hard", {out_vld, hard_err}, {!e.hard, e.hard});
                check(sw_trig == e.trig, "R4", "sw_trig", 128'(sw_trig), 128'(e.trig));
                check(crc_mismatch == e.mism, "R3", "crc_mismatch", 128'(crc_mismatch), 128'(e.mism));
                check(status == e.st, "R7", "status", 128'(status), 128'(e.st));
                if (!e.hard) begin
                    check(out_src == e.src, "R2", "out_src", 128'(out_src), 128'(e.src));
                    check(out_payload == e.pay, "R9", "payload", out_payload, e.pay);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check({out_vld, sw_trig, hard_err, crc_mismatch, out_src} == 0, "R10", "pulses", 128'({out_vld, sw_trig, hard_err}), 0);
        check(status == 0, "R10", "status", 128'(status), 0);
        read_cnt(0, 0, "R10");

        send_pair(11, 0, 1, 11, 0, 1, 0);   // R2 both good, match
        send_pair(12, 1, 1, 12, 0, 1, 0);   // R4 primary bad
        send_pair(13, 0, 1, 13, 1, 1, 0);   // R4 secondary bad
        send_pair(14, 1, 1, 14, 1, 1, 0);   // R5 both bad
        send_pair(15, 0, 1, 16, 0, 1, 0);   // R3 valid but different
        send_pair(17, 0, 1, 17, 0, 1, WT);  // R6 late at window edge
        send_pair(18, 0, 1, 18, 0, 0, 0);   // R6 secondary missing
        send_pair(19, 0, 0, 19, 0, 1, 0);   // R6 primary missing

        read_cnt(0, 3, "R8");
        read_cnt(0, 0, "R8");   // cleared by read
        read_cnt(1, 3, "R8");
        mdl_p = 0; mdl_s = 0;

        for (int k = 0; k < CMAX + 2; k++)
            send_pair(30 + k, 0, 1, 30 + k, 1, 1, 0);  // R8 drive secondary to saturation
        read_cnt(1, CMAX, "R8");
        read_cnt(0, 0, "R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule